// File: doc/BRIEF.md
# Dual-Rate Interface Clock Divider

This block derives the timing of an external bus clock from the system clock. It does not make a second clock domain. It produces two outputs that stay in the system-clock domain:

- a square-wave level that follows the external clock;
- a one-cycle strobe on every rising edge of that clock.

Logic downstream can use the strobe as a clock enable.

A 32-bit divider word holds two 16-bit divide values, one for each of two chip selects. A dual-rate control bit and the index of the active chip select choose the value in use. For a nonzero value D, the output period is 2·(⌊D/2⌋+1) system cycles. An odd value therefore gives the same rate as the even value just below it. A value of zero makes the output run at the full system rate.

A change to the divider word, the dual-rate bit or the chip-select index never shortens or stretches a period that has already started. The divider value is sampled only at the boundary where the next period begins.

Top module: `iface_clk_divider`

## Requirements
- R1: When the active divide value is 0 (bypass), `clk_level` stays 1 and `rise_stb` is 1 in every cycle, so the enable runs at the system rate.
- R2: For a nonzero active divide value D, each output period lasts N = 2·(⌊D/2⌋+1) system cycles. `clk_level` is 1 for the first N/2 cycles and 0 for the last N/2 cycles, giving a 50% duty cycle.
- R3: Odd divide values round down. D=1 gives a period of 2 cycles. D=2 and D=3 both give 4 cycles. D=4 gives 6 cycles.
- R4: With `dual_rate`=1, chip select 1 (`cs_sel`=1) uses `div_word[31:16]` and chip select 0 uses `div_word[15:0]`.
- R5: With `dual_rate`=0, both chip selects use `div_word[15:0]`. The upper half has no effect on the output.
- R6: The active divide value is sampled only on the cycle that begins a new period. A change to any input during a period takes effect at the start of the next period.
- R7: `rise_stb` is 1 for exactly the first cycle of each period, and that cycle is the one where `clk_level` goes high.
- R8: While `rst_n`=0, both outputs are 0. The first period starts on the first clock edge after reset is released, using the divide value selected at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_word | input | 32 | Two divide values: [15:0] for chip select 0, [31:16] for chip select 1 |
| dual_rate | input | 1 | 1 lets each chip select use its own divide value |
| cs_sel | input | 1 | Index of the active chip select |
| clk_level | output | 1 | Divided clock level, registered |
| rise_stb | output | 1 | One-cycle pulse on each rising edge of the divided clock |

## Verification
The bench builds the block with the default 16-bit field width. It uses small divide values (0, 1, 2, 3, 4 and 7) so that every rounding case and the bypass path come up within a few dozen cycles. Input changes are applied a chosen number of cycles before a period boundary, including changes where the old and new values differ in period length. This shows whether a change is applied early or only at the boundary. Leaving bypass is tested by switching on the last bypass cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    parameter int FIELD_W = 16;

    typedef struct packed {
        logic [FIELD_W:0]   cnt;
        logic [FIELD_W-1:0] act;
        logic               level;
        logic               stb;
    } div_state_t;
endpackage

// File: rtl/clkdiv_field_sel.sv
module clkdiv_field_sel #(
    parameter int W = 16
) (
    input  logic [2*W-1:0] word,
    input  logic           dual,
    input  logic           cs,
    output logic [W-1:0]   sel
);
    // The upper field is reachable only when per-select rates are enabled.
    always_comb begin
        if (dual && cs) sel = word[2*W-1:W];
        else            sel = word[W-1:0];
    end
endmodule

// File: rtl/clkdiv_period.sv
module clkdiv_period #(
    parameter int W = 16
) (
    input  logic [W-1:0] div,
    output logic [W:0]   last_idx,
    output logic [W:0]   half
);
    // Period = 2*(div/2 + 1) = (div | 1) + 1; bypass collapses to one cycle.
    always_comb begin
        if (div == '0) last_idx = '0;
        else           last_idx = {1'b0, div | {{(W-1){1'b0}}, 1'b1}};
        half = {2'b00, div[W-1:1]} + {{W{1'b0}}, 1'b1};
    end
endmodule

// File: rtl/iface_clk_divider.sv
module iface_clk_divider
    import clkdiv_pkg::*;
#(
    parameter int W = clkdiv_pkg::FIELD_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*W-1:0] div_word,
    input  logic           dual_rate,
    input  logic           cs_sel,
    output logic           clk_level,
    output logic           rise_stb
);
    localparam int CW = W + 1;

    div_state_t     state_d, state_q;
    logic [W-1:0]   sel_div;
    logic [CW-1:0]  last_idx;
    logic [CW-1:0]  half;
    logic [CW-1:0]  cnt_inc;
    logic           boundary;
    logic [W-1:0]   act_div;
    logic [CW-1:0]  cnt_now;

    clkdiv_field_sel #(.W(W)) u_sel (
        .word (div_word),
        .dual (dual_rate),
        .cs   (cs_sel),
        .sel  (sel_div)
    );

    // Period geometry of the value currently in force.
    clkdiv_period #(.W(W)) u_per (
        .div      (state_q.act),
        .last_idx (last_idx),
        .half     (half)
    );

    assign cnt_inc  = state_q.cnt + {{(CW-1){1'b0}}, 1'b1};
    assign boundary = (state_q.cnt == last_idx);

    always_comb begin
        state_d = state_q;
        if (boundary) begin
            state_d.act   = sel_div;
            state_d.cnt   = '0;
            state_d.level = 1'b1;
            state_d.stb   = 1'b1;
        end else begin
            state_d.cnt   = cnt_inc;
            state_d.level = (cnt_inc < half);
            state_d.stb   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign clk_level = state_q.level;
    assign rise_stb  = state_q.stb;
    assign act_div   = state_q.act;
    assign cnt_now   = state_q.cnt;
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         level,
    input logic         stb,
    input logic [W-1:0] act,
    input logic [W:0]   cnt,
    input logic [W:0]   last_idx
);
    // R1: bypass keeps re-arming the strobe every cycle.
    a_r1_bypass_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |=> stb);

    // R7: the strobe only ever marks a high level.
    a_r7_stb_with_high: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> level);

    // R2: a falling edge is never a period start.
    a_r2_fall_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level) |-> !stb);

    // R6: the divide value in force changes only when a period begins.
    a_r6_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> stb);

    // R2: the phase counter stays inside its period.
    a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_idx);

    // R8: reset clears both outputs.
    a_r8_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!level && !stb));
endmodule

bind iface_clk_divider clkdiv_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (clk_level),
    .stb      (rise_stb),
    .act      (act_div),
    .cnt      (cnt_now),
    .last_idx (last_idx)
);

// File: tb/iface_clk_divider_test.sv
module iface_clk_divider_test;
    typedef struct {
        logic  level;
        logic  stb;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] div_word = 32'h0;
    logic        dual_rate = 1'b0;
    logic        cs_sel = 1'b0;
    logic        clk_level;
    logic        rise_stb;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    iface_clk_divider uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_word  (div_word),
        .dual_rate (dual_rate),
        .cs_sel    (cs_sel),
        .clk_level (clk_level),
        .rise_stb  (rise_stb)
    );

    // Expected periods for divide value d, from R1..R3 and R7.
    task automatic push_periods(input int d, input int periods, input string tag);
        int n;
        n = (d == 0) ? 1 : 2 * (d / 2 + 1);
        for (int p = 0; p < periods; p++) begin
            for (int i = 0; i < n; i++) begin
                exp_t e;
                e.level = (d == 0) ? 1'b1 : (i < n / 2);
                e.stb   = (i == 0);
                e.tag   = tag;
                exp_q.push_back(e);
            end
        end
    endtask

    // Apply new inputs when j expected items of the old setting remain.
    task automatic switch_at(input int j, input logic [15:0] lo, input logic [15:0] hi,
                             input logic dual, input logic cs, input int new_d,
                             input int periods, input string tag);
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() <= j) break;
        end
        div_word  = {hi, lo};
        dual_rate = dual;
        cs_sel    = cs;
        push_periods(new_d, periods, tag);
    endtask

    // Monitor: compares one expected item per cycle, away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (clk_level !== e.level) begin
                    n_fails++;
                    $display("FAIL %s clk_level actual=%b expected=%b at %0t",
                             e.tag, clk_level, e.level, $time);
                end
                n_checks++;
                if (rise_stb !== e.stb) begin
                    n_fails++;
                    $display("FAIL R7 (%s) rise_stb actual=%b expected=%b at %0t",
                             e.tag, rise_stb, e.stb, $time);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        div_word  = {16'd1, 16'd4};
        dual_rate = 1'b0;
        cs_sel    = 1'b0;
        repeat (3) @(negedge clk);
        // R8: outputs quiet during reset.
        n_checks++;
        if (clk_level !== 1'b0 || rise_stb !== 1'b0) begin
            n_fails++;
            $display("FAIL R8 reset outputs actual=%b%b expected=00", clk_level, rise_stb);
        end
        push_periods(4, 2, "R8");
        rst_n = 1'b1;
        // R5: chip select 1 without dual rate still uses the lower field.
        switch_at(3, 16'd4, 16'd1, 1'b0, 1'b1, 4, 2, "R5");
        // R6: switch to a 2-cycle rate mid-period; old 6-cycle period must finish.
        switch_at(2, 16'd4, 16'd1, 1'b1, 1'b1, 1, 3, "R6");
        // R3: odd value 3 rounds to a 4-cycle period.
        switch_at(1, 16'd4, 16'd3, 1'b1, 1'b1, 3, 2, "R3");
        // R2: even value 2 also gives 4 cycles at 50% duty.
        switch_at(2, 16'd4, 16'd2, 1'b1, 1'b1, 2, 2, "R2");
        // R1: lower field 0 on chip select 0 bypasses the divider.
        switch_at(3, 16'd0, 16'd2, 1'b1, 1'b0, 0, 5, "R1");
        // R2: leave bypass on its last cycle into an 8-cycle period.
        switch_at(0, 16'd7, 16'd2, 1'b1, 1'b0, 7, 2, "R2");
        // R4: dual rate, chip select 1 picks the upper field.
        switch_at(2, 16'd7, 16'd2, 1'b1, 1'b1, 2, 2, "R4");
        while (exp_q.size() > 0) @(negedge clk);
        #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule